// File: doc/BRIEF.md
# Two-wire bus pad guard: synchroniser, spike filter and recovery override

This block sits between the two open-drain pads of a two-wire serial bus (clock line and data line) and the protocol engine that drives them. Each incoming pad level is brought into the system clock domain by a two-flop synchroniser. It then passes through a spike filter that only accepts a new level once it has held for a programmable number of clock cycles. The filtered levels go to the protocol engine and can also be read by software.

On the output side, each pad's drive-low enable combines the protocol engine's request with a software override bit. Software can therefore pull either line low by itself, for example to clock a stuck target free during bus recovery. Register writes carry a per-bit write mask, so one override bit can be changed without a read-modify-write of the other. A filter length of zero bypasses the filter.

Top module: `i2c_pad_guard`

## Requirements
- R1: With a filter length of 0, a change on a pad input appears on the matching filtered level output after exactly two rising clock edges.
- R2: With a filter length L greater than 0, the filtered level takes a new value only after the synchronised input has differed from it for L consecutive cycles, which gives a total latency of 2+L edges. A pulse shorter than L cycles leaves the filtered level unchanged.
- R3: Reading the control word (`reg_addr` = 0) returns the filtered clock-line level in bit 0 and the filtered data-line level in bit 1. All bits above bit 3 read as zero.
- R4: Bit 2 of the control word is the clock-line force-low override and bit 3 is the data-line force-low override. Both are written at `reg_addr` = 0 and read back in the same positions.
- R5: A write changes only the register bits whose `reg_wmask` bit is 1. In particular, a write that masks in only bit 2 leaves the data-line override unchanged.
- R6: Each pad's drive-low enable is high exactly when the engine requests a low on that line or that line's override bit is set.
- R7: After reset, both filtered levels are 1, both override bits are 0, both drive-low enables are 0 with no engine request, and the filter length equals the parameter `LEN_RST`.
- R8: The filter length is a `LEN_W`-bit register at `reg_addr` = 1, written with masking and read back zero-extended. Its maximum value 2^LEN_W-1 rejects a pulse of 2^LEN_W-2 cycles and accepts one of 2^LEN_W-1 cycles.
- R9: When the synchronised input returns to the filtered level before the count completes, the count restarts. Two short pulses separated by one cycle are therefore not added together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_pad_i | input | 1 | Raw clock-line pad level |
| sda_pad_i | input | 1 | Raw data-line pad level |
| eng_scl_low | input | 1 | Protocol engine request to drive the clock line low |
| eng_sda_low | input | 1 | Protocol engine request to drive the data line low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control word, 1 filter length |
| reg_wdata | input | REG_W | Write data |
| reg_wmask | input | REG_W | Per-bit write enable |
| reg_rdata | output | REG_W | Read data of the selected register |
| scl_level | output | 1 | Filtered clock-line level |
| sda_level | output | 1 | Filtered data-line level |
| scl_oe | output | 1 | Clock-line pad drive-low enable |
| sda_oe | output | 1 | Data-line pad drive-low enable |

## Verification
The bench builds the block with `LEN_W` = 4, `REG_W` = 8 and `LEN_RST` = 3. The narrow counter makes the top filter length, 15, cheap to reach, so the boundary between a 14-cycle and a 15-cycle pulse is exercised. It also exercises the counter's compare at its full width. Lengths of 0, 1 and 4 cover bypass, the shortest real filter and a mid-range value with glitches of 1 to 3 cycles and back-to-back glitches.

// File: rtl/pad_guard_pkg.sv
package pad_guard_pkg;

  localparam int unsigned NUM_LINES = 2;
  localparam int unsigned IDX_SCL   = 0;
  localparam int unsigned IDX_SDA   = 1;

  // Control word bit positions; software decodes these.
  localparam int unsigned CW_SCL_LVL = 0;
  localparam int unsigned CW_SDA_LVL = 1;
  localparam int unsigned CW_SCL_FRC = 2;
  localparam int unsigned CW_SDA_FRC = 3;
  localparam int unsigned CW_BITS    = 4;

  typedef enum logic {
    SEL_CTL = 1'b0,
    SEL_LEN = 1'b1
  } reg_sel_e;

endpackage

// File: rtl/pg_sync2.sv
module pg_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic meta_q, meta_n;
  logic stab_q, stab_n;

  always_comb begin
    meta_n = d_i;
    stab_n = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      stab_q <= RST_VAL;
    end else begin
      meta_q <= meta_n;
      stab_q <= stab_n;
    end
  end

  assign q_o = stab_q;

endmodule

// File: rtl/pg_spike_filter.sv
module pg_spike_filter #(
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             lvl_o
);

  localparam int unsigned CMP_W = LEN_W + 1;

  logic             held_q, held_n;
  logic [LEN_W-1:0] run_q, run_n;
  logic [CMP_W-1:0] run_inc;
  logic             bypass;
  logic             upd_en;

  assign bypass  = (len_i == '0);
  assign run_inc = CMP_W'(run_q) + CMP_W'(1);

  always_comb begin
    held_n = held_q;
    run_n  = run_q;
    if (bypass) begin
      held_n = lvl_i;
      run_n  = '0;
    end else if (lvl_i != held_q) begin
      if (run_inc >= CMP_W'(len_i)) begin
        held_n = lvl_i;
        run_n  = '0;
      end else begin
        run_n  = run_inc[LEN_W-1:0];
      end
    end else begin
      run_n = '0;
    end
  end

  assign upd_en = (held_n != held_q) || (run_n != run_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b1;
      run_q  <= '0;
    end else if (upd_en) begin
      held_q <= held_n;
      run_q  <= run_n;
    end
  end

  assign lvl_o = bypass ? lvl_i : held_q;

endmodule

// File: rtl/pg_ctl_regs.sv
module pg_ctl_regs
  import pad_guard_pkg::*;
#(
  parameter int unsigned REG_W   = 16,
  parameter int unsigned LEN_W   = 8,
  parameter int unsigned LEN_RST = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_i,
  input  logic                 sel_i,
  input  logic [REG_W-1:0]     wdata_i,
  input  logic [REG_W-1:0]     wmask_i,
  input  logic [NUM_LINES-1:0] lvl_i,
  output logic [NUM_LINES-1:0] frc_o,
  output logic [LEN_W-1:0]     len_o,
  output logic [REG_W-1:0]     rdata_o
);

  logic [NUM_LINES-1:0] frc_q, frc_n;
  logic [LEN_W-1:0]     len_q, len_n;
  logic [REG_W-1:0]     ctl_view, len_view;
  logic [REG_W-1:0]     ctl_merge, len_merge;
  logic                 ctl_en, len_en;
  logic                 unused_merge_hi;

  assign ctl_view = REG_W'({frc_q[IDX_SDA], frc_q[IDX_SCL], lvl_i[IDX_SDA], lvl_i[IDX_SCL]});
  assign len_view = REG_W'(len_q);

  assign ctl_merge = (ctl_view & ~wmask_i) | (wdata_i & wmask_i);
  assign len_merge = (len_view & ~wmask_i) | (wdata_i & wmask_i);

  assign unused_merge_hi = ^{ctl_merge[CW_SDA_LVL:0], ctl_merge[REG_W-1:CW_BITS],
                             len_merge};

  assign ctl_en = wr_i && (reg_sel_e'(sel_i) == SEL_CTL);
  assign len_en = wr_i && (reg_sel_e'(sel_i) == SEL_LEN);

  always_comb begin
    frc_n = frc_q;
    len_n = len_q;
    if (ctl_en) begin
      frc_n[IDX_SCL] = ctl_merge[CW_SCL_FRC];
      frc_n[IDX_SDA] = ctl_merge[CW_SDA_FRC];
    end
    if (len_en) begin
      len_n = len_merge[LEN_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frc_q <= '0;
    end else if (ctl_en) begin
      frc_q <= frc_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= LEN_W'(LEN_RST);
    end else if (len_en) begin
      len_q <= len_n;
    end
  end

  assign frc_o   = frc_q;
  assign len_o   = len_q;
  assign rdata_o = (reg_sel_e'(sel_i) == SEL_LEN) ? len_view : ctl_view;

endmodule

// File: rtl/i2c_pad_guard.sv
module i2c_pad_guard
  import pad_guard_pkg::*;
#(
  parameter int unsigned REG_W   = 16,
  parameter int unsigned LEN_W   = 8,
  parameter int unsigned LEN_RST = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_pad_i,
  input  logic             sda_pad_i,
  input  logic             eng_scl_low,
  input  logic             eng_sda_low,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic [REG_W-1:0] reg_wmask,
  output logic [REG_W-1:0] reg_rdata,
  output logic             scl_level,
  output logic             sda_level,
  output logic             scl_oe,
  output logic             sda_oe
);

  // Reset: asserted asynchronously, released after two clock edges.
  logic rst_meta_q, rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  logic [NUM_LINES-1:0] pad_vec, sync_vec, filt_vec, eng_vec, frc_vec, oe_vec;
  logic [LEN_W-1:0]     len_q;

  assign pad_vec[IDX_SCL] = scl_pad_i;
  assign pad_vec[IDX_SDA] = sda_pad_i;
  assign eng_vec[IDX_SCL] = eng_scl_low;
  assign eng_vec[IDX_SDA] = eng_sda_low;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    pg_sync2 #(
      .RST_VAL (1'b1)
    ) u_sync (
      .clk   (clk),
      .rst_n (rst_core_n),
      .d_i   (pad_vec[g]),
      .q_o   (sync_vec[g])
    );

    pg_spike_filter #(
      .LEN_W (LEN_W)
    ) u_filt (
      .clk   (clk),
      .rst_n (rst_core_n),
      .lvl_i (sync_vec[g]),
      .len_i (len_q),
      .lvl_o (filt_vec[g])
    );

    assign oe_vec[g] = eng_vec[g] | frc_vec[g];
  end

  pg_ctl_regs #(
    .REG_W   (REG_W),
    .LEN_W   (LEN_W),
    .LEN_RST (LEN_RST)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_i    (reg_wr),
    .sel_i   (reg_addr),
    .wdata_i (reg_wdata),
    .wmask_i (reg_wmask),
    .lvl_i   (filt_vec),
    .frc_o   (frc_vec),
    .len_o   (len_q),
    .rdata_o (reg_rdata)
  );

  assign scl_level = filt_vec[IDX_SCL];
  assign sda_level = filt_vec[IDX_SDA];
  assign scl_oe    = oe_vec[IDX_SCL];
  assign sda_oe    = oe_vec[IDX_SDA];

endmodule

// File: rtl/pg_guard_chk.sv
module pg_guard_chk #(
  parameter int unsigned LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       sync_lvl,
  input logic [1:0]       filt_lvl,
  input logic [1:0]       frc,
  input logic [1:0]       eng,
  input logic [1:0]       oe,
  input logic [LEN_W-1:0] len,
  input logic             wr,
  input logic             addr,
  input logic             sda_frc_mask
);

  // R6: an override forces the pad enable
  assert_frc_drives_oe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frc != 2'b00) |-> ((oe & frc) == frc));

  // R6: an engine request forces the pad enable
  assert_eng_drives_oe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eng != 2'b00) |-> ((oe & eng) == eng));

  // R6: nothing requested, nothing driven
  assert_idle_no_oe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((eng | frc) == 2'b00) |-> (oe == 2'b00));

  // R2: no change while the synchronised level agrees with the filtered one
  assert_hold_scl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((len != '0) && ($past(len) != '0) && ($past(sync_lvl[0]) == $past(filt_lvl[0])))
      |-> (filt_lvl[0] == $past(filt_lvl[0])));

  assert_hold_sda_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((len != '0) && ($past(len) != '0) && ($past(sync_lvl[1]) == $past(filt_lvl[1])))
      |-> (filt_lvl[1] == $past(filt_lvl[1])));

  // R2: an accepted change takes the synchronised value
  assert_accept_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((len != '0) && ($past(len) != '0) && (filt_lvl != $past(filt_lvl)))
      |-> (((filt_lvl ^ $past(filt_lvl)) & (filt_lvl ^ $past(sync_lvl))) == 2'b00));

  // R5: a masked-out data-line override bit keeps its value
  assert_mask_keeps_sda_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (addr == 1'b0) && !sda_frc_mask) |=> $stable(frc[1]));

endmodule

bind i2c_pad_guard pg_guard_chk #(
  .LEN_W (LEN_W)
) u_guard_chk (
  .clk          (clk),
  .rst_n        (rst_core_n),
  .sync_lvl     (sync_vec),
  .filt_lvl     (filt_vec),
  .frc          (frc_vec),
  .eng          (eng_vec),
  .oe           (oe_vec),
  .len          (len_q),
  .wr           (reg_wr),
  .addr         (reg_addr),
  .sda_frc_mask (reg_wmask[3])
);

// File: tb/sim_i2c_pad_guard.sv
`timescale 1ns/1ps
module sim_i2c_pad_guard;

  localparam int REG_W   = 8;
  localparam int LEN_W   = 4;
  localparam int LEN_RST = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             scl_pad_i = 1'b1, sda_pad_i = 1'b1;
  logic             eng_scl_low = 1'b0, eng_sda_low = 1'b0;
  logic             reg_wr = 1'b0, reg_addr = 1'b0;
  logic [REG_W-1:0] reg_wdata = '0, reg_wmask = '0;
  logic [REG_W-1:0] reg_rdata;
  logic             scl_level, sda_level, scl_oe, sda_oe;

  always #10 clk = ~clk;

  i2c_pad_guard #(.REG_W(REG_W), .LEN_W(LEN_W), .LEN_RST(LEN_RST)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_pad_i(scl_pad_i), .sda_pad_i(sda_pad_i),
    .eng_scl_low(eng_scl_low), .eng_sda_low(eng_sda_low), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wmask(reg_wmask),
    .reg_rdata(reg_rdata), .scl_level(scl_level), .sda_level(sda_level),
    .scl_oe(scl_oe), .sda_oe(sda_oe));

  int    n_run = 0, n_fail = 0;
  string cur_req = "R7";
  bit    cmp_on = 1'b0;
  bit    done = 1'b0;

  // Behavioural reference: pipeline of pad samples and a run length per line.
  int m_p1[2], m_p2[2], m_out[2], m_runlen[2];
  int m_len;
  int m_frc[2];

  function automatic int exp_lvl(int i);
    return (m_len == 0) ? m_p2[i] : m_out[i];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_p1[i] = 1; m_p2[i] = 1; m_out[i] = 1; m_runlen[i] = 0; m_frc[i] = 0;
      end
      m_len = LEN_RST;
    end else begin
      for (int i = 0; i < 2; i++) begin
        int pad;
        pad = (i == 0) ? int'(scl_pad_i) : int'(sda_pad_i);
        if (m_len == 0) begin
          m_out[i] = m_p2[i]; m_runlen[i] = 0;
        end else if (m_p2[i] != m_out[i]) begin
          m_runlen[i]++;
          if (m_runlen[i] >= m_len) begin
            m_out[i] = m_p2[i]; m_runlen[i] = 0;
          end
        end else begin
          m_runlen[i] = 0;
        end
        m_p2[i] = m_p1[i];
        m_p1[i] = pad;
      end
      if (reg_wr && !reg_addr) begin
        if (reg_wmask[2]) m_frc[0] = int'(reg_wdata[2]);
        if (reg_wmask[3]) m_frc[1] = int'(reg_wdata[3]);
      end
      if (reg_wr && reg_addr) begin
        for (int b = 0; b < LEN_W; b++)
          if (reg_wmask[b]) begin
            if (reg_wdata[b]) m_len = m_len | (1 << b);
            else m_len = m_len & ~(1 << b);
          end
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      int exp_rd;
      exp_rd = reg_addr ? m_len
             : (m_frc[1] << 3) | (m_frc[0] << 2) | (exp_lvl(1) << 1) | exp_lvl(0);
      chk(cur_req, "scl_level", int'(scl_level), exp_lvl(0));
      chk(cur_req, "sda_level", int'(sda_level), exp_lvl(1));
      chk("R6", "scl_oe", int'(scl_oe), int'(eng_scl_low) | m_frc[0]);
      chk("R6", "sda_oe", int'(sda_oe), int'(eng_sda_low) | m_frc[1]);
      chk(reg_addr ? "R8" : "R3", "reg_rdata", int'(reg_rdata), exp_rd);
    end
  end

  task automatic tick();
    @(negedge clk); #2;
  endtask

  task automatic wr(input logic a, input int d, input int m);
    tick(); reg_wr = 1'b1; reg_addr = a; reg_wdata = REG_W'(d); reg_wmask = REG_W'(m);
    tick(); reg_wr = 1'b0; reg_wdata = '0; reg_wmask = '0;
  endtask

  task automatic pulse_sda(input int n);
    tick(); sda_pad_i = 1'b0;
    repeat (n) tick();
    sda_pad_i = 1'b1;
    repeat (LEN_W + 18) tick();
  endtask

  initial begin
    #4000000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    #2 rst_n = 1'b1;
    cmp_on = 1'b1;
    repeat (4) tick();

    // R7: reset state through the ports
    @(negedge clk);
    chk("R7", "ctl word", int'(reg_rdata), 3);
    chk("R7", "oe", int'({sda_oe, scl_oe}), 0);
    tick(); reg_addr = 1'b1;
    @(negedge clk);
    chk("R7", "len", int'(reg_rdata), LEN_RST);
    tick(); reg_addr = 1'b0;

    // R1: bypass latency of two edges
    cur_req = "R1";
    wr(1'b1, 0, 8'hFF);
    tick(); scl_pad_i = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R1", "scl after 1 edge", int'(scl_level), 1);
    @(posedge clk); @(negedge clk);
    chk("R1", "scl after 2 edges", int'(scl_level), 0);
    tick(); scl_pad_i = 1'b1;
    tick(); sda_pad_i = 1'b0;
    tick(); sda_pad_i = 1'b1;
    repeat (5) tick();

    // R2: length 4, glitches of 1..3 rejected, 4 accepted
    cur_req = "R2";
    wr(1'b1, 4, 8'h0F);
    for (int n = 1; n <= 3; n++) pulse_sda(n);
    chk("R2", "sda after short pulses", int'(sda_level), 1);
    tick(); sda_pad_i = 1'b0;
    repeat (5) @(posedge clk); @(negedge clk);
    chk("R2", "sda after 5 edges", int'(sda_level), 1);
    @(posedge clk); @(negedge clk);
    chk("R2", "sda after 6 edges", int'(sda_level), 0);
    tick(); sda_pad_i = 1'b1;
    repeat (10) tick();
    wr(1'b1, 1, 8'h0F);
    pulse_sda(1);
    pulse_sda(2);

    // R9: two 3-cycle glitches one cycle apart at length 4
    cur_req = "R9";
    wr(1'b1, 4, 8'h0F);
    tick(); sda_pad_i = 1'b0; repeat (3) tick();
    sda_pad_i = 1'b1; tick();
    sda_pad_i = 1'b0; repeat (3) tick();
    sda_pad_i = 1'b1; repeat (12) tick();
    chk("R9", "sda stays high", int'(sda_level), 1);

    // R8: maximum length boundary
    cur_req = "R8";
    wr(1'b1, 15, 8'hFF);
    tick(); reg_addr = 1'b1; tick(); tick(); reg_addr = 1'b0;
    pulse_sda(14);
    pulse_sda(15);
    wr(1'b1, 8'h2, 8'h02);   // masked: len 15 -> 15 keeps bit1 set
    wr(1'b1, 8'h0, 8'h08);   // masked: 15 -> 7
    tick(); reg_addr = 1'b1; tick(); tick(); reg_addr = 1'b0;
    wr(1'b1, 2, 8'h0F);

    // R4 and R5: override bits and masked writes
    cur_req = "R4";
    wr(1'b0, 8'h04, 8'h04);
    @(negedge clk);
    chk("R4", "scl force readback", int'(reg_rdata[2]), 1);
    wr(1'b0, 8'h08, 8'h08);
    @(negedge clk);
    chk("R4", "sda force readback", int'(reg_rdata[3]), 1);
    cur_req = "R5";
    wr(1'b0, 8'h00, 8'h04);
    @(negedge clk);
    chk("R5", "sda force kept", int'(reg_rdata[3]), 1);
    chk("R5", "scl force cleared", int'(reg_rdata[2]), 0);
    wr(1'b0, 8'h04, 8'h04);
    wr(1'b0, 8'hFF, 8'h00);
    wr(1'b0, 8'h00, 8'h0C);

    // R6: engine requests alone and with overrides
    cur_req = "R6";
    for (int v = 0; v < 4; v++) begin
      tick(); eng_scl_low = v[0]; eng_sda_low = v[1];
      tick();
    end
    wr(1'b0, 8'h08, 8'h08);
    for (int v = 0; v < 4; v++) begin
      tick(); eng_scl_low = v[0]; eng_sda_low = v[1];
      tick();
    end
    eng_scl_low = 1'b0; eng_sda_low = 1'b0;
    wr(1'b0, 8'h00, 8'hFF);

    // R3: monitor bits follow both lines
    cur_req = "R3";
    tick(); scl_pad_i = 1'b0; repeat (6) tick();
    @(negedge clk);
    chk("R3", "bit0 low", int'(reg_rdata[0]), 0);
    sda_pad_i = 1'b0; repeat (6) tick();
    scl_pad_i = 1'b1; repeat (6) tick();
    sda_pad_i = 1'b1; repeat (6) tick();
    @(negedge clk);
    chk("R3", "upper bits", int'(reg_rdata[7:4]), 0);

    repeat (3) tick();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule